// File: doc/BRIEF.md
# Nibble-Serial Word Read Port

This block connects a single read requester to an external memory through a narrow link. The address goes out on a 4-bit bus and the read data comes back on a 4-bit bus. Every read takes a slot of four clocks. Slots follow each other with no gap, so the address bus always carries an address. One 16-bit word address reaches 64 Ki words, which is 128 kB. The memory side must return each data nibble a fixed number of clocks after the matching address nibble. The port collects the four data nibbles into a word and signals it with a one-cycle pulse.

The requester offers an address with a valid/ready handshake. The port accepts it only on the final clock of a slot, and sends it in the slot that follows. A slot that starts with no accepted request sends the previous address again and returns no word. After either reset is released, the first slot always sends the fixed pattern 0x8421, and the data that comes back for it is thrown away. This lets the memory side find where slots begin. While the client reset is held, the port does not issue reads. Instead it echoes the incoming data bus onto the address bus through two registers, so the round-trip delay of the memory side can be measured.

Top module: `nibble_read_port`

## Requirements
- R1: While `rst` is high, `mem_addr_o` is 0 and `req_ready` is 0. From the second cycle of `rst` onward, `rsp_valid` is 0.
- R2: With `rst` and `client_rst` both low, slots of four clocks repeat back to back. The first slot starts in the first cycle in which both resets are low. `req_ready` is 1 only in the fourth clock of each slot.
- R3: A slot sends its 16-bit address one nibble per clock, lowest first: bits [3:0], then [7:4], then [11:8], then [15:12].
- R4: The first slot after release of either reset sends 0x8421, which appears on the bus as the nibbles 1, 2, 4, 8. No response is produced for this slot.
- R5: For a read whose slot starts in cycle c, data nibble k is taken from `mem_data_i` in cycle c+DATA_LAT+k and placed in `rsp_data[4k+3:4k]`. `rsp_valid` is 1 for exactly one cycle, c+DATA_LAT+4, and that word is on `rsp_data` in the same cycle.
- R6: A slot that begins without an accepted request repeats the previous slot's address and produces no `rsp_valid`.
- R7: While `client_rst` is high and `rst` is low, `req_ready` is 0. `mem_addr_o` equals the value `mem_data_i` had two cycles earlier.
- R8: Reads in flight when `client_rst` rises never produce a response. `rsp_valid` is 0 from the second cycle of `client_rst`.
- R9: An address accepted with `req_valid` and `req_ready` both high is the address of the very next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole port |
| client_rst | input | 1 | Client held in reset; enables loopback and stops reads |
| req_valid | input | 1 | Read request offered |
| req_addr | input | 16 | Word address of the offered read |
| req_ready | output | 1 | Request accepted at this clock edge if valid |
| mem_addr_o | output | 4 | Address nibble to memory, or loopback value |
| mem_data_i | input | 4 | Data nibble from memory |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds a returned word |
| rsp_data | output | 16 | Assembled read word |

## Verification
A memory model rebuilds every address from the bus nibbles, assuming lowest-first order, and answers with a scrambled copy of it. A nibble swap or a wrong latency therefore shows up as wrong response data. The model does not rely on the port's own view of the address. The request stream covers back-to-back accepts, requests mixed with idle slots, and the all-zero and all-ones addresses. Idle slots separate correct address repetition and response suppression from a port that answers every slot. A client reset in the middle of a read, followed by loopback patterns, separates correct flushing and the two-register echo from stale responses or a wrong echo depth. A full reset part way through the run checks that the sync pattern is sent again.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = 16;
    localparam int NIBS   = ADDR_W / NIB_W;
    localparam int PH_W   = $clog2(NIBS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIBS - 1);
    localparam logic [ADDR_W-1:0] SYNC_ADDR = 16'h8421;
    localparam int LOOP_STAGES = 2;

    typedef enum logic [1:0] {
        MODE_RESET = 2'd0,
        MODE_LOOP  = 2'd1,
        MODE_RUN   = 2'd2
    } port_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              live;
    } slot_t;

    function automatic logic [NIB_W-1:0] pick_nibble(logic [ADDR_W-1:0] w,
                                                     logic [PH_W-1:0] idx);
        return w[idx*NIB_W +: NIB_W];
    endfunction

    function automatic port_mode_e decode_mode(logic hard_rst, logic soft_rst);
        if (hard_rst)      return MODE_RESET;
        else if (soft_rst) return MODE_LOOP;
        else               return MODE_RUN;
    endfunction
endpackage

// File: rtl/nsr_slot_seq.sv
module nsr_slot_seq
    import nsr_pkg::*;
(
    input  logic                clk,
    input  port_mode_e          mode,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ready,
    output logic [PH_W-1:0]     phase,
    output slot_t               slot,
    output logic                slot_start
);
    always_ff @(posedge clk) begin
        if (mode != MODE_RUN) begin
            phase <= '0;
            slot  <= '{addr: SYNC_ADDR, live: 1'b0};
        end else begin
            phase <= phase + PH_W'(1);
            if (phase == PH_LAST) begin
                if (req_valid) begin
                    slot <= '{addr: req_addr, live: 1'b1};
                end else begin
                    slot.live <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        req_ready  = (mode == MODE_RUN) && (phase == PH_LAST);
        slot_start = (mode == MODE_RUN) && (phase == '0) && slot.live;
    end
endmodule

// File: rtl/nsr_serializer.sv
module nsr_serializer
    import nsr_pkg::*;
(
    input  logic              clk,
    input  port_mode_e        mode,
    input  logic [NIB_W-1:0]  mem_data_i,
    input  slot_t             slot,
    input  logic [PH_W-1:0]   phase,
    output logic [NIB_W-1:0]  mem_addr_o
);
    logic [NIB_W-1:0] echo_q [LOOP_STAGES];

    genvar g;
    generate
        for (g = 0; g < LOOP_STAGES; g++) begin : g_echo
            always_ff @(posedge clk) begin
                if (mode == MODE_RESET) begin
                    echo_q[g] <= '0;
                end else if (g == 0) begin
                    echo_q[g] <= mem_data_i;
                end else begin
                    echo_q[g] <= echo_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_LOOP: mem_addr_o = echo_q[LOOP_STAGES-1];
            MODE_RUN:  mem_addr_o = pick_nibble(slot.addr, phase);
            default:   mem_addr_o = '0;
        endcase
    end
endmodule

// File: rtl/nsr_deserializer.sv
module nsr_deserializer
    import nsr_pkg::*;
#(
    parameter int DATA_LAT = 12
) (
    input  logic              clk,
    input  port_mode_e        mode,
    input  logic [NIB_W-1:0]  mem_data_i,
    input  logic              slot_start,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_data
);
    localparam int DEPTH  = DATA_LAT + NIBS - 1;
    localparam int HIST_W = (NIBS - 1) * NIB_W;

    logic [DEPTH-1:0]  tag_q;
    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (mode != MODE_RUN) begin
            tag_q     <= '0;
            hist_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            tag_q     <= {tag_q[DEPTH-2:0], slot_start};
            hist_q    <= {mem_data_i, hist_q[HIST_W-1:NIB_W]};
            rsp_valid <= tag_q[DEPTH-1];
            if (tag_q[DEPTH-1]) begin
                rsp_data <= {mem_data_i, hist_q};
            end
        end
    end
endmodule

// File: rtl/nibble_read_port.sv
module nibble_read_port
    import nsr_pkg::*;
#(
    parameter int DATA_LAT = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        client_rst,
    input  logic        req_valid,
    input  logic [15:0] req_addr,
    output logic        req_ready,
    output logic [3:0]  mem_addr_o,
    input  logic [3:0]  mem_data_i,
    output logic        rsp_valid,
    output logic [15:0] rsp_data
);
    port_mode_e       mode;
    logic [PH_W-1:0]  phase;
    slot_t            slot;
    logic             slot_start;

    assign mode = decode_mode(rst, client_rst);

    nsr_slot_seq u_seq (
        .clk        (clk),
        .mode       (mode),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .phase      (phase),
        .slot       (slot),
        .slot_start (slot_start)
    );

    nsr_serializer u_ser (
        .clk        (clk),
        .mode       (mode),
        .mem_data_i (mem_data_i),
        .slot       (slot),
        .phase      (phase),
        .mem_addr_o (mem_addr_o)
    );

    nsr_deserializer #(.DATA_LAT(DATA_LAT)) u_des (
        .clk        (clk),
        .mode       (mode),
        .mem_data_i (mem_data_i),
        .slot_start (slot_start),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );
endmodule

// File: rtl/nibble_read_port_chk.sv
module nibble_read_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       client_rst,
    input logic       req_ready,
    input logic [3:0] mem_addr_o,
    input logic [3:0] mem_data_i,
    input logic       rsp_valid
);
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !req_ready));

    assert_ready_gap_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    assert_sync_first_R4: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $fell(client_rst)) |-> (mem_addr_o == 4'h1));

    assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_no_ready_loop_R7: assert property (@(posedge clk) disable iff (rst)
        client_rst |-> !req_ready);

    assert_echo_depth_R7: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && client_rst && $past(client_rst) && $past(client_rst, 2))
            |-> (mem_addr_o == $past(mem_data_i, 2)));
endmodule

bind nibble_read_port nibble_read_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .client_rst (client_rst),
    .req_ready  (req_ready),
    .mem_addr_o (mem_addr_o),
    .mem_data_i (mem_data_i),
    .rsp_valid  (rsp_valid)
);

// File: tb/tb_nibble_read_port.sv
`timescale 1ns/1ps
module tb_nibble_read_port;
    localparam int LAT = 12;
    localparam logic [15:0] SYNC = 16'h8421;
    localparam int NV = 10;
    localparam logic [16:0] VEC [NV] = '{
        17'h11234, 17'h10000, 17'h1FFFF, 17'h00000, 17'h1A5A5,
        17'h00000, 17'h00000, 17'h18421, 17'h10F0F, 17'h17E81
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1, client_rst = 1'b0, req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready, rsp_valid;
    logic [3:0]  mem_addr_o;
    logic [3:0]  mem_data_i = '0;
    logic [15:0] rsp_data;

    nibble_read_port #(.DATA_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .client_rst(client_rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int total = 0, bad = 0;

    function automatic logic [15:0] mem_word(logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got %h exp %h", tag, act, exp);
        end
    endtask

    // memory model and monitor, one process at the falling edge
    int          runc = 0, lbc = 0, rc = 0, ph, s, b;
    logic [3:0]  alog [64];
    logic [3:0]  lbh  [64];
    logic [15:0] slot_addr = SYNC, pend_addr = '0, word, a;
    bit          pend = 0;
    int          q_due [$];
    logic [15:0] q_dat [$];

    always @(negedge clk) begin
        if (rst) begin
            if (rc >= 1) begin
                check(mem_addr_o == 4'h0, "R1 addr bus", 16'(mem_addr_o), 16'h0);
                check(!req_ready, "R1 ready", 16'(req_ready), 16'h0);
                check(!rsp_valid, "R1 rsp_valid", 16'(rsp_valid), 16'h0);
            end
            rc++; runc = 0; lbc = 0; pend = 0;
            q_due.delete(); q_dat.delete();
            mem_data_i = 4'h0;
        end else if (client_rst) begin
            rc = 0;
            check(!req_ready, "R7 ready in loopback", 16'(req_ready), 16'h0);
            if (lbc >= 1)
                check(!rsp_valid, "R8 flushed read", 16'(rsp_valid), 16'h0);
            if (lbc >= 2)
                check(mem_addr_o == lbh[(lbc-2)%64], "R7 echo",
                      16'(mem_addr_o), 16'(lbh[(lbc-2)%64]));
            lbh[lbc%64] = 4'(lbc*7 + 3);
            mem_data_i = lbh[lbc%64];
            lbc++; runc = 0; pend = 0;
            q_due.delete(); q_dat.delete();
        end else begin
            rc = 0; lbc = 0;
            ph = runc % 4;
            if (ph == 0) begin
                if (runc == 0) slot_addr = SYNC;
                else if (pend) begin
                    slot_addr = pend_addr;
                    q_due.push_back(runc + LAT + 4);
                    q_dat.push_back(mem_word(pend_addr));
                end
                pend = 0;
            end
            if (runc < 4)
                check(mem_addr_o == slot_addr[ph*4 +: 4], "R4 sync nibble",
                      16'(mem_addr_o), 16'(slot_addr[ph*4 +: 4]));
            else
                check(mem_addr_o == slot_addr[ph*4 +: 4], "R3 R9 slot nibble",
                      16'(mem_addr_o), 16'(slot_addr[ph*4 +: 4]));
            check(req_ready == (ph == 3), "R2 ready position",
                  16'(req_ready), 16'(ph == 3));
            if (req_ready && req_valid) begin
                pend = 1; pend_addr = req_addr;
            end
            if (q_due.size() > 0 && q_due[0] == runc) begin
                check(rsp_valid, "R5 rsp_valid", 16'(rsp_valid), 16'h1);
                check(rsp_data == q_dat[0], "R5 rsp_data", rsp_data, q_dat[0]);
                void'(q_due.pop_front()); void'(q_dat.pop_front());
            end else begin
                check(!rsp_valid, "R6 unexpected response", 16'(rsp_valid), 16'h0);
            end
            alog[runc%64] = mem_addr_o;
            if (runc >= LAT) begin
                s = runc - LAT;
                b = s - (s % 4);
                a = {alog[(b+3)%64], alog[(b+2)%64], alog[(b+1)%64], alog[b%64]};
                word = mem_word(a);
                mem_data_i = word[(s%4)*4 +: 4];
            end else begin
                mem_data_i = 4'hF;
            end
            runc++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic issue(bit v, logic [15:0] ad);
        req_valid = v;
        req_addr  = ad;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(8 * 50000);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        tick(4);
        rst = 1'b0;
        // table of requests; zero-flag entries leave a slot idle (R6)
        for (int i = 0; i < NV; i++) issue(VEC[i][16], VEC[i][15:0]);
        tick(LAT + 8);
        // client reset with a read in flight: R7 loopback, R8 flush, R4 resync
        issue(1'b1, 16'hC3D2);
        tick(2);
        client_rst = 1'b1;
        tick(10);
        client_rst = 1'b0;
        issue(1'b1, 16'h0001);
        issue(1'b1, 16'hBEEF);
        tick(LAT + 8);
        // full reset part way through the run, then one more read (R1, R4)
        issue(1'b1, 16'h6B10);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        issue(1'b1, 16'h4D2B);
        tick(LAT + 8);
        check(q_due.size() == 0, "R5 missing responses", 16'(q_due.size()), 16'h0);
        summary();
        $finish;
    end
endmodule